// File: doc/BRIEF.md
# ADC Result Window Comparator

The comparator watches the stream of converted samples coming out of an analog-to-digital converter. It tests each sample against two programmable reference values and keeps one sticky status flag per monitored channel. Each monitored channel has its own condition bit. With the window control off, that bit chooses between "sample below reference 0" and "sample above reference 0". With the window control on, it chooses between "sample strictly inside the window set by the two references" and "sample outside it". Every comparison is strict, so a sample equal to a reference never matches.

Six channels are monitored: channel numbers 0 to 4 and channel number 11. The channel number carried with a sample is the bit index into the condition and status vectors. A small register write port does two jobs. It loads the condition vector, but only while the converter reports idle. It clears status flags when software writes 0 to a flag bit. A one-cycle event pulse reports every sample that met its channel's condition. The comparison is registered, so a flag and the event pulse appear one clock after the sample strobe.

Top module: `adc_window_cmp`

## Requirements
- R1: With `winEn` = 0 and a condition bit of 0, a strobed sample on that channel sets its flag when `ref0` > sample.
- R2: With `winEn` = 0 and a condition bit of 1, a strobed sample on that channel sets its flag when `ref0` < sample.
- R3: With `winEn` = 1 and a condition bit of 1, the flag is set when `ref0` < sample < `ref1`.
- R4: With `winEn` = 1 and a condition bit of 0, the flag is set when sample < `ref0` or sample > `ref1`.
- R5: A sample equal to `ref0`, or to `ref1` where `ref1` takes part in the test, never satisfies that test.
- R6: With `winEn` = 1 and `ref0` >= `ref1`, the inside condition never matches, and the outside condition still follows the two strict tests on their own.
- R7: Only channels whose bit is set in the monitor mask 16'h081F (bits 0..4 and 11) are compared. A strobe on any other channel, or a cycle with `resValid` = 0, leaves all flags unchanged and gives no event.
- R8: Condition bits and status bits outside the monitor mask always read 0, and writes to them have no effect.
- R9: After reset, `condSel`, `status` and `cmpEvent` are all 0.
- R10: A write to address 0 (the condition vector) is discarded while `convBusy` = 1 and takes effect when `convBusy` = 0.
- R11: Flags are sticky. A write to address 1 clears each flag whose data bit is 0 and leaves alone each flag whose data bit is 1. If a set and a clear hit the same flag in the same cycle, the flag ends up set.
- R12: The flag and `cmpEvent` change on the clock edge that samples the strobe. `cmpEvent` is high for exactly one cycle for each matching strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| resValid | input | 1 | Conversion result strobe |
| resCh | input | 4 | Channel number of the result (bit index) |
| resData | input | DATA_W (12) | Converted value |
| ref0 | input | DATA_W (12) | Reference value 0 |
| ref1 | input | DATA_W (12) | Reference value 1 |
| winEn | input | 1 | 1 = window mode, 0 = single-threshold mode |
| convBusy | input | 1 | Converter running; blocks condition writes |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 1 | 0 = condition vector, 1 = status clear |
| regWrData | input | 16 | Write data |
| condSel | output | 16 | Condition vector readback |
| status | output | 16 | Sticky per-channel status flags |
| cmpEvent | output | 1 | One-cycle pulse for each matching sample |

## Verification
The bench builds the block with DATA_W = 4 and leaves the channel count at 16 and the monitor mask at its default. The narrow sample width makes an exhaustive sweep practical: every sample value is tried against every pair of reference values, in both modes and with both polarities of the condition bit. That reaches every equality case and every inverted window. Directed sequences then cover the mask boundary (channels 5, 11 and 15), the busy guard, the clear semantics, the collision of a set with a clear, and the one-cycle latency.

// File: rtl/awc_pkg.sv
package awc_pkg;
  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic sampleGo;  // qualified result on a monitored channel
    logic condWe;    // condition vector load (busy guard applied)
    logic clrWe;     // status clear write
  } awcStrobes_t;

  localparam logic COND_ADDR = 1'b0;
  localparam logic CLR_ADDR  = 1'b1;
endpackage

// File: rtl/awc_ctrl.sv
module awc_ctrl
  import awc_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter logic [NUM_CH-1:0] MON_MASK = 16'h081F,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic            resValid,
  input  logic [CH_W-1:0] resCh,
  input  logic            convBusy,
  input  logic            regWrEn,
  input  logic            regAddr,
  output awcStrobes_t     strobes
);
  logic chMonitored;

  always_comb begin
    chMonitored      = MON_MASK[resCh];
    strobes.sampleGo = resValid && chMonitored;
    strobes.condWe   = regWrEn && (regAddr == COND_ADDR) && !convBusy;
    strobes.clrWe    = regWrEn && (regAddr == CLR_ADDR);
  end
endmodule

// File: rtl/awc_datapath.sv
module awc_datapath
  import awc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 16,
  parameter logic [NUM_CH-1:0] MON_MASK = 16'h081F,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  awcStrobes_t       strobes,
  input  logic [CH_W-1:0]   resCh,
  input  logic [DATA_W-1:0] resData,
  input  logic [DATA_W-1:0] ref0,
  input  logic [DATA_W-1:0] ref1,
  input  logic              winEn,
  input  logic [NUM_CH-1:0] wrData,
  output logic [NUM_CH-1:0] condSel,
  output logic [NUM_CH-1:0] status,
  output logic              cmpEvent
);
  logic belowRef0, aboveRef0, belowRef1, aboveRef1;
  logic condBit, matchRaw, hit;

  // Strict magnitude tests shared by both modes.
  always_comb begin
    belowRef0 = resData < ref0;
    aboveRef0 = resData > ref0;
    belowRef1 = resData < ref1;
    aboveRef1 = resData > ref1;
    condBit   = condSel[resCh];
    if (winEn) begin
      matchRaw = condBit ? (aboveRef0 && belowRef1) : (belowRef0 || aboveRef1);
    end else begin
      matchRaw = condBit ? aboveRef0 : belowRef0;
    end
    hit = strobes.sampleGo && matchRaw;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    if (MON_MASK[i]) begin : gMon
      logic condQ;
      logic flagQ;
      logic setI, clrI;

      always_comb begin
        setI = hit && (resCh == CH_W'(i));
        clrI = strobes.clrWe && !wrData[i];
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          condQ <= 1'b0;
        end else if (strobes.condWe) begin
          condQ <= wrData[i];
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          flagQ <= 1'b0;
        end else if (setI) begin
          flagQ <= 1'b1;
        end else if (clrI) begin
          flagQ <= 1'b0;
        end
      end

      assign condSel[i] = condQ;
      assign status[i]  = flagQ;
    end else begin : gRsv
      assign condSel[i] = 1'b0;
      assign status[i]  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpEvent <= 1'b0;
    end else begin
      cmpEvent <= hit;
    end
  end
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp
  import awc_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 16,
  parameter logic [NUM_CH-1:0] MON_MASK = 16'h081F,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              resValid,
  input  logic [CH_W-1:0]   resCh,
  input  logic [DATA_W-1:0] resData,
  input  logic [DATA_W-1:0] ref0,
  input  logic [DATA_W-1:0] ref1,
  input  logic              winEn,
  input  logic              convBusy,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [NUM_CH-1:0] regWrData,
  output logic [NUM_CH-1:0] condSel,
  output logic [NUM_CH-1:0] status,
  output logic              cmpEvent
);
  awcStrobes_t       strobes;
  logic [NUM_CH-1:0] wrMasked;

  assign wrMasked = regWrData & MON_MASK;

  awc_ctrl #(.NUM_CH(NUM_CH), .MON_MASK(MON_MASK)) uCtrl (
    .resValid (resValid),
    .resCh    (resCh),
    .convBusy (convBusy),
    .regWrEn  (regWrEn),
    .regAddr  (regAddr),
    .strobes  (strobes)
  );

  awc_datapath #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .MON_MASK(MON_MASK)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .resCh    (resCh),
    .resData  (resData),
    .ref0     (ref0),
    .ref1     (ref1),
    .winEn    (winEn),
    .wrData   (wrMasked),
    .condSel  (condSel),
    .status   (status),
    .cmpEvent (cmpEvent)
  );
endmodule

// File: rtl/awc_checker.sv
module awc_checker #(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 16,
  parameter logic [NUM_CH-1:0] MON_MASK = 16'h081F,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rstN,
  input logic              resValid,
  input logic [CH_W-1:0]   resCh,
  input logic [DATA_W-1:0] ref0,
  input logic [DATA_W-1:0] ref1,
  input logic              winEn,
  input logic              convBusy,
  input logic              regWrEn,
  input logic              regAddr,
  input logic [NUM_CH-1:0] condSel,
  input logic [NUM_CH-1:0] status,
  input logic              cmpEvent
);
  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    ((status & ~MON_MASK) == '0) && ((condSel & ~MON_MASK) == '0));

  p_busy_discard_r10: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && !regAddr && convBusy) |=> $stable(condSel));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!(resValid && MON_MASK[resCh]) && !(regWrEn && regAddr)) |=> $stable(status));

  p_sticky_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr) |=> ((status & $past(status)) == $past(status)));

  p_event_cause_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmpEvent |-> $past(resValid));

  p_event_flag_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmpEvent |-> status[$past(resCh)]);

  p_inverted_never_r6: assert property (@(posedge clk) disable iff (!rstN)
    (resValid && winEn && (ref0 >= ref1) && condSel[resCh]) |=> !cmpEvent);
endmodule

bind adc_window_cmp awc_checker #(.DATA_W(DATA_W), .NUM_CH(NUM_CH), .MON_MASK(MON_MASK)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .resValid (resValid),
  .resCh    (resCh),
  .ref0     (ref0),
  .ref1     (ref1),
  .winEn    (winEn),
  .convBusy (convBusy),
  .regWrEn  (regWrEn),
  .regAddr  (regAddr),
  .condSel  (condSel),
  .status   (status),
  .cmpEvent (cmpEvent)
);

// File: tb/adc_window_cmp_test.sv
`timescale 1ns/1ps
module adc_window_cmp_test;
  localparam int DW = 4;
  localparam int NCH = 16;
  localparam logic [15:0] MON = 16'h081F;

  logic          clk = 1'b0;
  logic          rstN;
  logic          resValid;
  logic [3:0]    resCh;
  logic [DW-1:0] resData, ref0, ref1;
  logic          winEn, convBusy, regWrEn, regAddr;
  logic [15:0]   regWrData;
  logic [15:0]   condSel, status;
  logic          cmpEvent;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  adc_window_cmp #(.DATA_W(DW), .NUM_CH(NCH), .MON_MASK(MON)) uut (
    .clk(clk), .rstN(rstN), .resValid(resValid), .resCh(resCh), .resData(resData),
    .ref0(ref0), .ref1(ref1), .winEn(winEn), .convBusy(convBusy),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .condSel(condSel), .status(status), .cmpEvent(cmpEvent)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic bit expMatch(int d, int r0, int r1, bit win, bit c);
    if (!win) return c ? (r0 < d) : (r0 > d);
    return c ? (d > r0 && d < r1) : (d < r0 || d > r1);
  endfunction

  function automatic string tagFor(int d, int r0, int r1, bit win, bit c);
    if (d == r0 || (win && d == r1)) return "R5";
    if (win && r0 >= r1) return "R6";
    if (!win) return c ? "R2" : "R1";
    return c ? "R3" : "R4";
  endfunction

  task automatic wrReg(logic a, logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic strobe(logic [3:0] ch, logic [DW-1:0] d);
    @(negedge clk);
    resValid = 1'b1; resCh = ch; resData = d;
    @(negedge clk);
    resValid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; resValid = 1'b0; resCh = '0; resData = '0; ref0 = '0; ref1 = '0;
    winEn = 1'b0; convBusy = 1'b0; regWrEn = 1'b0; regAddr = 1'b0; regWrData = '0;
    repeat (3) @(negedge clk);
    chk("R9 cond", condSel, 0);
    chk("R9 status", status, 0);
    chk("R9 event", cmpEvent, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R9 cond after release", condSel, 0);
    chk("R9 status after release", status, 0);

    // Channel 0 uses condition 0, channel 1 uses condition 1.
    wrReg(1'b0, 16'h0002);
    chk("R10 idle write", condSel, 16'h0002);

    // Exhaustive sweep over the references, samples and modes.
    for (int w = 0; w < 2; w++) begin
      for (int r0 = 0; r0 < (1 << DW); r0++) begin
        for (int r1 = 0; r1 < (1 << DW); r1++) begin
          for (int d = 0; d < (1 << DW); d++) begin
            bit e0, e1;
            e0 = expMatch(d, r0, r1, w[0], 1'b0);
            e1 = expMatch(d, r0, r1, w[0], 1'b1);
            @(negedge clk);
            winEn = w[0]; ref0 = DW'(r0); ref1 = DW'(r1);
            regWrEn = 1'b1; regAddr = 1'b1; regWrData = 16'h0000;
            @(negedge clk);
            regWrEn = 1'b0;
            resValid = 1'b1; resCh = 4'd0; resData = DW'(d);
            @(negedge clk);
            chk({tagFor(d, r0, r1, w[0], 1'b0), " event ch0"}, cmpEvent, e0);
            resCh = 4'd1;
            @(negedge clk);
            resValid = 1'b0;
            chk({tagFor(d, r0, r1, w[0], 1'b1), " event ch1"}, cmpEvent, e1);
            chk({tagFor(d, r0, r1, w[0], 1'b0), "/", tagFor(d, r0, r1, w[0], 1'b1), " flags"},
                status, {14'b0, e1, e0});
          end
        end
      end
    end

    // Busy guard.
    convBusy = 1'b1;
    wrReg(1'b0, 16'h001F);
    chk("R10 busy write discarded", condSel, 16'h0002);
    convBusy = 1'b0;
    wrReg(1'b0, 16'hFFFF);
    chk("R8 reserved condition bits", condSel, 16'h081F);

    // Channel mask: all condition bits are 1, single mode, matches above 8.
    winEn = 1'b0; ref0 = DW'(8); ref1 = DW'(0);
    wrReg(1'b1, 16'h0000);
    chk("R11 clear all", status, 0);
    strobe(4'd5, DW'(12));
    chk("R7 ch5 event", cmpEvent, 0);
    chk("R7 ch5 flags", status, 0);
    strobe(4'd15, DW'(12));
    chk("R7 ch15 flags", status, 0);
    @(negedge clk);
    resValid = 1'b1; resCh = 4'd11; resData = DW'(12);
    #1;
    chk("R12 no flag before edge", status, 0);
    @(negedge clk);
    resValid = 1'b0;
    chk("R12 event ch11", cmpEvent, 1);
    chk("R2 flag ch11", status, 16'h0800);
    resCh = 4'd0; resData = DW'(12);
    @(negedge clk);
    chk("R12 event one cycle", cmpEvent, 0);
    chk("R7 no strobe hold", status, 16'h0800);

    // Sticky behaviour and clear semantics.
    strobe(4'd11, DW'(3));
    chk("R11 sticky on miss", status, 16'h0800);
    chk("R12 no event on miss", cmpEvent, 0);
    wrReg(1'b1, 16'hFFFF);
    chk("R11 write 1 keeps", status, 16'h0800);
    strobe(4'd0, DW'(12));
    chk("R11 second flag", status, 16'h0801);
    wrReg(1'b1, 16'hF7FF);
    chk("R11 selective clear", status, 16'h0001);

    // Set and clear in the same cycle.
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = 16'h0000;
    resValid = 1'b1; resCh = 4'd0; resData = DW'(12);
    @(negedge clk);
    regWrEn = 1'b0; resValid = 1'b0;
    chk("R11 set wins", status, 16'h0001);
    chk("R12 event on collision", cmpEvent, 1);
    wrReg(1'b1, 16'h0000);
    chk("R11 final clear", status, 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule